// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block computes the twelve syndromes of a received 31-symbol Reed-Solomon codeword. The code corrects up to six symbol errors. Each symbol is 5 bits wide, and all arithmetic is in GF(32), built from the primitive polynomial x^5 + x^2 + 1. The consecutive roots of the generator are alpha^19 through alpha^30, so syndrome S_j is the received polynomial evaluated at alpha^(18+j).

Symbols arrive one per accepted clock, highest-degree coefficient first, and are qualified by a valid strobe. A start strobe marks the first symbol of a word. Each syndrome has its own accumulator. On every accepted symbol, the accumulator multiplies its value by a fixed field constant and then adds the symbol (Horner evaluation). A new word may begin on the clock after the previous word ends. When a word is complete, the finished syndromes move to a holding register, and a one-cycle done pulse goes out with them. A flag shows whether every syndrome is zero, so later stages can skip correction for a clean word.

Top module: `rs_syndrome_calc`

## Requirements
- R1: After a complete word r(x) = sum r_i x^i, the bus `synd_o[5*(j-1)+4 : 5*(j-1)]` holds S_j = r(alpha^(18+j)) for j = 1..12. The first symbol of a word is the coefficient of x^30 and the last is the coefficient of x^0.
- R2: Field products reduce modulo x^5 + x^2 + 1, and alpha is the class of x. Symbol bit b is the coefficient of x^b.
- R3: `done_o` is high for exactly one cycle. It is sampled high two clock edges after the edge that accepts the 31st symbol of a word.
- R4: Between done pulses, `synd_o` and `zero_o` keep their values.
- R5: `zero_o` is 1 exactly when all twelve syndromes in `synd_o` are zero. A valid codeword with no injected errors gives all-zero syndromes.
- R6: A cycle with `valid_i` and `sob_i` both high starts a new word with that symbol, even part-way through a word. The abandoned partial word produces no done pulse.
- R7: Cycles with `valid_i` low are not counted and do not change any accumulator, so gaps inside a word do not change the result.
- R8: Words may follow back to back, with the next start on the clock after a last symbol. Each word gives its own correct syndromes.
- R9: A symbol with `valid_i` high and `sob_i` low, arriving when no word is open (after reset or after a word ends), is ignored. It raises no done pulse and does not change `synd_o`.
- R10: During reset `synd_o` is 0, `done_o` is 0 and `zero_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_i | input | 5 | Received symbol |
| valid_i | input | 1 | Symbol on `sym_i` is accepted this cycle |
| sob_i | input | 1 | Accepted symbol is the first (x^30) of a word |
| synd_o | output | 60 | S_1 in bits 4:0 up to S_12 in bits 59:55 |
| done_o | output | 1 | One-cycle pulse when new syndromes are presented |
| zero_o | output | 1 | All presented syndromes are zero |

## Verification
Several properties are checked on every cycle by the assertions:
- the fixed delay from a last symbol to the done pulse, and that the pulse lasts one cycle;
- the holding of outputs between pulses;
- the agreement of the zero flag with the presented syndromes;
- the loading of every accumulator by a start symbol;
- the freezing of the accumulators on idle cycles and on stray symbols.

Only the bench's scenarios can show that the syndrome values themselves are correct. For that, the bench encodes random messages with the generator built from roots alpha^19..alpha^30, injects zero to six symbol errors, and evaluates the polynomial with its own log tables. The scenarios also cover single errors at both ends of the word, back-to-back words, random gaps, a restart part-way through a word, and stray symbols outside a word.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

  // Field GF(2^5): elements are 5-bit vectors, bit b = coefficient of x^b
  localparam int SYM_W    = 5;
  localparam int GF_ORDER = (1 << SYM_W) - 1;
  // x^5 reduces to x^2 + 1
  localparam logic [SYM_W-1:0] POLY_LOW = 5'b00101;

  // multiply by alpha (= x) and reduce
  function automatic logic [SYM_W-1:0] gf_xtime(input logic [SYM_W-1:0] a);
    return {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? POLY_LOW : '0);
  endfunction

  // general product, Horner over the bits of b; a constant b folds to XORs
  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                              input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] r;
    r = '0;
    for (int i = SYM_W - 1; i >= 0; i--) begin
      r = gf_xtime(r) ^ (b[i] ? a : '0);
    end
    return r;
  endfunction

  // alpha^e as a field element, for elaboration-time constants
  function automatic logic [SYM_W-1:0] gf_alpha_pow(input int e);
    logic [SYM_W-1:0] r;
    r = 1;
    for (int i = 0; i < GF_ORDER; i++) begin
      if (i < (e % GF_ORDER)) r = gf_xtime(r);
    end
    return r;
  endfunction

endpackage

// File: rtl/rs_syn_cell.sv
module rs_syn_cell
  import rs_syn_pkg::*;
#(
  parameter int ROOT_EXP = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic [SYM_W-1:0] acc_o
);

  localparam logic [SYM_W-1:0] ROOT = gf_alpha_pow(ROOT_EXP);

  logic [SYM_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (load_i) begin
      acc_q <= sym_i;
    end else if (step_i) begin
      acc_q <= gf_mul(acc_q, ROOT) ^ sym_i;
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/rs_syn_ctrl.sv
module rs_syn_ctrl #(
  parameter int N_SYM = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic sob_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic word_end_o
);

  localparam int CNT_W = $clog2(N_SYM + 1);

  // symbols accepted in the open word; zero means no word is open
  logic [CNT_W-1:0] cnt_q;
  logic             word_end_q;

  assign load_o = valid_i & sob_i;
  assign step_o = valid_i & ~sob_i & (cnt_q != '0);
  assign last_o = load_o ? (N_SYM == 1)
                         : (step_o && (cnt_q == CNT_W'(N_SYM - 1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      word_end_q <= 1'b0;
    end else begin
      word_end_q <= last_o;
      if (last_o)      cnt_q <= '0;
      else if (load_o) cnt_q <= CNT_W'(1);
      else if (step_o) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign word_end_o = word_end_q;

endmodule

// File: rtl/rs_syn_out.sv
module rs_syn_out #(
  parameter int SYN_W = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [SYN_W-1:0] acc_i,
  output logic [SYN_W-1:0] synd_o,
  output logic             done_o,
  output logic             zero_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synd_o <= '0;
      done_o <= 1'b0;
      zero_o <= 1'b1;
    end else begin
      done_o <= capture_i;
      if (capture_i) begin
        synd_o <= acc_i;
        zero_o <= (acc_i == '0);
      end
    end
  end

endmodule

// File: rtl/rs_syndrome_calc.sv
module rs_syndrome_calc
  import rs_syn_pkg::*;
#(
  parameter int N_SYM      = 31,
  parameter int N_PAR      = 12,
  parameter int FIRST_ROOT = 19
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SYM_W-1:0]         sym_i,
  input  logic                     valid_i,
  input  logic                     sob_i,
  output logic [N_PAR*SYM_W-1:0]   synd_o,
  output logic                     done_o,
  output logic                     zero_o
);

  localparam int SYN_W = N_PAR * SYM_W;

  // named internal events, observed by the bound checker
  logic             load;
  logic             step;
  logic             last;
  logic             word_end;
  logic [SYN_W-1:0] acc_flat;

  rs_syn_ctrl #(.N_SYM(N_SYM)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .sob_i      (sob_i),
    .load_o     (load),
    .step_o     (step),
    .last_o     (last),
    .word_end_o (word_end)
  );

  // one accumulator per consecutive generator root
  for (genvar j = 0; j < N_PAR; j++) begin : g_cell
    rs_syn_cell #(.ROOT_EXP(FIRST_ROOT + j)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .step_i (step),
      .sym_i  (sym_i),
      .acc_o  (acc_flat[j*SYM_W +: SYM_W])
    );
  end

  // accumulators hold the finished word for exactly the edge at which
  // the next word's first symbol may overwrite them; capture them there
  rs_syn_out #(.SYN_W(SYN_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (word_end),
    .acc_i     (acc_flat),
    .synd_o    (synd_o),
    .done_o    (done_o),
    .zero_o    (zero_o)
  );

endmodule

// File: rtl/rs_syndrome_calc_chk.sv
module rs_syndrome_calc_chk #(
  parameter int N_PAR = 12,
  parameter int SYM_W = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   valid_i,
  input logic                   sob_i,
  input logic [SYM_W-1:0]       sym_i,
  input logic                   load,
  input logic                   step,
  input logic                   last,
  input logic                   word_end,
  input logic [N_PAR*SYM_W-1:0] acc_flat,
  input logic [N_PAR*SYM_W-1:0] synd_o,
  input logic                   done_o,
  input logic                   zero_o
);

  p_end_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> word_end);

  p_done_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> done_o);

  p_done_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(word_end));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_hold_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(synd_o) && $stable(zero_o)));

  p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o == (synd_o == '0));

  p_start_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_flat == {N_PAR{$past(sym_i)}}));

  p_gap_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(acc_flat));

  p_stray_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !sob_i && !step) |=> ($stable(acc_flat) && !word_end));

endmodule

bind rs_syndrome_calc rs_syndrome_calc_chk #(
  .N_PAR (N_PAR),
  .SYM_W (rs_syn_pkg::SYM_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid_i  (valid_i),
  .sob_i    (sob_i),
  .sym_i    (sym_i),
  .load     (load),
  .step     (step),
  .last     (last),
  .word_end (word_end),
  .acc_flat (acc_flat),
  .synd_o   (synd_o),
  .done_o   (done_o),
  .zero_o   (zero_o)
);

// File: tb/rs_syndrome_calc_tb.sv
`timescale 1ns/1ps
module rs_syndrome_calc_tb;

  localparam int NS = 31;
  localparam int NP = 12;
  localparam int SW = NP * 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [4:0]    sym;
  logic          valid, sob;
  logic [SW-1:0] synd;
  logic          done, zero;

  always #2 clk = ~clk;

  rs_syndrome_calc u_dut (
    .clk(clk), .rst_n(rst_n), .sym_i(sym), .valid_i(valid), .sob_i(sob),
    .synd_o(synd), .done_o(done), .zero_o(zero)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [4:0]    exp_t [0:30];
  int            log_t [0:31];
  logic [4:0]    gpoly [0:12];
  logic [4:0]    cw    [0:30];
  logic [SW-1:0] pend, held;
  int            cd;
  string         tag;

  // table-based field product, alpha^k from the power table
  function automatic logic [4:0] fm(input logic [4:0] a, input logic [4:0] b);
    if (a == 0 || b == 0) return 5'd0;
    return exp_t[(log_t[a] + log_t[b]) % 31];
  endfunction

  // direct evaluation S_j = sum cw[i] * alpha^(i*(18+j))
  function automatic logic [SW-1:0] exp_syn();
    logic [SW-1:0] r;
    logic [4:0] s;
    r = '0;
    for (int j = 1; j <= NP; j++) begin
      s = 0;
      for (int i = 0; i < NS; i++) s ^= fm(cw[i], exp_t[(i * (18 + j)) % 31]);
      r[(j-1)*5 +: 5] = s;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [SW-1:0] act,
                     input logic [SW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (cd == 1) begin
      chk(done == 1'b1, {tag, " R3 done pulse"}, SW'(done), SW'(1));
      chk(synd == pend, {tag, " R1 syndromes"}, synd, pend);
      chk(zero == (pend == '0), {tag, " R5 zero flag"}, SW'(zero), SW'(pend == '0));
      held = pend;
    end else begin
      chk(done == 1'b0, {tag, " R3 no stray done"}, SW'(done), SW'(0));
      chk(synd == held, {tag, " R4 hold"}, synd, held);
    end
    if (cd > 0) cd--;
  endtask

  // send symbols of cw from x^30 down to x^lo, with random idle gaps
  task automatic send_word(input int gap_pct, input int lo);
    for (int i = NS - 1; i >= lo; i--) begin
      while ((gap_pct > 0) && (($urandom % 100) < gap_pct)) begin
        tick(); valid = 1'b0; sob = 1'b0; sym = 5'($urandom);
      end
      tick(); valid = 1'b1; sob = (i == NS - 1); sym = cw[i];
      if (i == 0) begin cd = 2; pend = exp_syn(); end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      tick(); valid = 1'b0; sob = 1'b0;
    end
  endtask

  task automatic clear_word();
    for (int i = 0; i < NS; i++) cw[i] = 5'd0;
  endtask

  // systematic encoder: message in x^30..x^12, remainder by g(x) below
  task automatic encode_random();
    logic [4:0] rem [0:11];
    logic [4:0] fb;
    for (int k = 0; k < 12; k++) rem[k] = 0;
    for (int i = NS - 1; i >= 12; i--) begin
      cw[i] = 5'($urandom);
      fb = cw[i] ^ rem[11];
      for (int k = 11; k >= 1; k--) rem[k] = rem[k-1] ^ fm(fb, gpoly[k]);
      rem[0] = fm(fb, gpoly[0]);
    end
    for (int k = 0; k < 12; k++) cw[k] = rem[k];
  endtask

  task automatic inject(input int nerr);
    bit hit [0:30];
    int placed, pos;
    for (int i = 0; i < NS; i++) hit[i] = 0;
    placed = 0;
    while (placed < nerr) begin
      pos = $urandom % NS;
      if (!hit[pos]) begin
        hit[pos] = 1;
        cw[pos] ^= 5'(1 + ($urandom % 31));
        placed++;
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [4:0] v;
    void'($urandom(32'h5eed));
    // R2: power table of alpha under x^5 = x^2 + 1
    exp_t[0] = 5'd1;
    for (int i = 1; i < 31; i++) begin
      v = exp_t[i-1];
      exp_t[i] = v[4] ? ({v[3:0], 1'b0} ^ 5'b00101) : {v[3:0], 1'b0};
    end
    log_t[0] = 0;
    for (int i = 0; i < 31; i++) log_t[exp_t[i]] = i;
    // generator = product of (x + alpha^r), r = 19..30
    for (int k = 0; k <= 12; k++) gpoly[k] = 0;
    gpoly[0] = 1;
    for (int r = 19; r <= 30; r++) begin
      for (int k = 12; k >= 1; k--) gpoly[k] = gpoly[k-1] ^ fm(gpoly[k], exp_t[r]);
      gpoly[0] = fm(gpoly[0], exp_t[r]);
    end
    tag = "init";
    chk(gpoly[0] == exp_t[15] && gpoly[12] == 1, "R2 generator constant term",
        SW'(gpoly[0]), SW'(exp_t[15]));

    rst_n = 1'b0; valid = 1'b0; sob = 1'b0; sym = 5'd0;
    cd = 0; held = '0; pend = '0;
    repeat (4) @(negedge clk);
    tag = "reset";
    chk(synd == '0, "R10 reset syndromes", synd, '0);
    chk(done == 1'b0, "R10 reset done", SW'(done), SW'(0));
    chk(zero == 1'b1, "R10 reset zero flag", SW'(zero), SW'(1));
    rst_n = 1'b1;

    // R1: a lone 1 at x^0 gives every S_j = 1
    tag = "R1 last-symbol x0";
    clear_word(); cw[0] = 5'd1; send_word(0, 0); idle(3);
    // R2: a lone 1 at x^30 gives S_j = alpha^(30*(18+j))
    tag = "R2 first-symbol x30";
    clear_word(); cw[30] = 5'd1; send_word(0, 0); idle(3);
    // R5: all-zero word
    tag = "R5 zero word";
    clear_word(); send_word(0, 0); idle(3);

    // R8: back-to-back random codewords with 0..6 errors
    tag = "R8 back-to-back";
    for (int w = 0; w < 21; w++) begin
      encode_random(); inject(w % 7); send_word(0, 0);
    end
    idle(3);

    // R7: random gaps inside words
    tag = "R7 gaps";
    for (int w = 0; w < 8; w++) begin
      encode_random(); inject($urandom % 7); send_word(30, 0);
    end
    idle(3);

    // R6: restart part-way; only the second word reports
    tag = "R6 restart";
    encode_random(); inject(3); send_word(0, 20);
    encode_random(); inject(2); send_word(0, 0);
    idle(3);

    // R9: stray symbols outside a word: no done, outputs held
    tag = "R9 stray";
    for (int k = 0; k < 6; k++) begin
      tick(); valid = 1'b1; sob = 1'b0; sym = 5'($urandom | 1);
    end
    idle(4);
    chk(synd == held, "R9 stray symbols left syndromes", synd, held);
    encode_random(); send_word(0, 0); idle(3);

    // R5: clean codewords report zero
    tag = "R5 clean";
    for (int w = 0; w < 3; w++) begin
      encode_random(); send_word(10, 0);
    end
    idle(4);

    summary();
    $finish;
  end

endmodule